// File: doc/BRIEF.md
# Memory-Mapped Byte-Stream Bridge

This block lets a host processor exchange a byte-oriented command stream with an accelerator over an AXI-Lite slave port. Each host write to the push-data register places one byte into a transmit queue. The queue is presented to the accelerator's command consumer through a valid/ready byte port. Bytes the consumer sends back enter a receive queue through a second valid/ready port. The host drains that queue one byte per read of the pop-data register, and each such read removes the byte it returns.

Two status words report whether the transmit queue can accept a byte and whether the receive queue holds one. A control bit emits a one-cycle soft-reset pulse, which empties both queues and is also driven out to the consumer. An identity word, a core-count word and a 32-bit scratch register complete the map. The scratch register lets the host confirm bus connectivity.

Registers sit on 32-bit word boundaries in the low 32 bytes of the address window:

| Offset | Register |
|--------|----------|
| 0x000 | push data |
| 0x004 | push status |
| 0x008 | pop data |
| 0x00C | pop status |
| 0x010 | control |
| 0x014 | identity |
| 0x018 | scratch |
| 0x01C | core count |

Top module: `mmio_stream_bridge`

## Requirements
- R1: A write to offset 0x000 pushes write-data bits 7:0 into the transmit queue and ignores bits 31:8. The bytes appear on `tx_byte_o` in write order, and each leaves the queue on a cycle where `tx_valid_o` and `tx_ready_i` are both high.
- R2: Reading offset 0x004 returns 1 in bit 0 while the transmit queue is not full, 0 when it is full, and 0 in bits 31:1.
- R3: A write to offset 0x000 while the transmit queue is full is discarded, leaves the queue contents unchanged, and still completes with an OKAY (2'b00) response.
- R4: Reading offset 0x008 while the receive queue holds data returns the oldest byte in bits 7:0, with bits 31:8 zero, and removes that byte in the same access.
- R5: Reading offset 0x00C returns 1 in bit 0 while the receive queue is not empty, and 0 otherwise.
- R6: Reading offset 0x008 while the receive queue is empty returns 0 and leaves the queue unchanged.
- R7: Writing offset 0x010 with bit 0 set drives `soft_reset_o` high for exactly one cycle, on the cycle after the write is accepted, and empties both queues. Writing bit 0 as 0 produces no pulse, and offset 0x010 reads 0 once the pulse is over.
- R8: Offset 0x014 reads the parameter `ID_WORD`, 0xF2020310 by default. Offset 0x01C reads the parameter `NUM_CORES`, 16 by default.
- R9: Offset 0x018 is a 32-bit register that returns the last value written, and a soft reset leaves it unchanged.
- R10: An address outside 0x000..0x01C, or one whose bits 1:0 are not zero, reads 0 and responds OKAY. A write to such an address changes no register and no queue.
- R11: A write is accepted only on a cycle where address and data are both valid. Each accepted access gets exactly one response, with OKAY status, and `s_bvalid` and `s_rvalid` stay high until their ready inputs are high. Read data stays stable while the read response is held.
- R12: `rx_ready_i`'s partner `rx_ready_o` is high exactly while the receive queue is not full, and a byte offered on `rx_byte_i` while the queue is full is dropped. `tx_valid_o` is high exactly while the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response status |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response status |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| tx_byte_o | output | 8 | Head byte of the transmit queue, toward the consumer |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_ready_i | input | 1 | Consumer takes the head byte |
| rx_byte_i | input | 8 | Response byte from the consumer |
| rx_valid_i | input | 1 | Response byte valid |
| rx_ready_o | output | 1 | Receive queue has room |
| soft_reset_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The queues are tried with a small depth of 4, using repeated fill-to-full and drain-to-empty rounds. Each round uses a different arithmetic byte pattern with junk in the upper write-data bits. This separates correct ordering and correct masking from a lost, repeated or shifted byte, and from a missed full or empty boundary.

Overflow and underflow attempts come right after the boundary is reached. A push after an empty read separates "pointer untouched" from "pointer moved". The control bit is driven with both 1 and 0 while the queues hold data, to separate a flush from a no-op.

A walking-ones sweep of the scratch register and a scan of mapped, unmapped and misaligned offsets separate decode faults from data-path faults. Held response channels show whether the handshake waits for the host.

// File: rtl/msb_pkg.sv
package msb_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WIN_LSB = 5;    // mapped window spans 8 words
   localparam logic [1:0] RESP_OKAY = 2'b00;

   typedef enum logic [2:0] {
      IDX_PUSH    = 3'd0,
      IDX_PUSH_ST = 3'd1,
      IDX_POP     = 3'd2,
      IDX_POP_ST  = 3'd3,
      IDX_CTRL    = 3'd4,
      IDX_ID      = 3'd5,
      IDX_SCRATCH = 3'd6,
      IDX_NCORE   = 3'd7
   } reg_idx_e;

   typedef struct packed {
      logic     hit;
      reg_idx_e idx;
   } reg_sel_t;
endpackage

// File: rtl/msb_byte_fifo.sv
module msb_byte_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("msb_byte_fifo: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("msb_byte_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W:0]   wr_ptr;
   logic [PTR_W:0]   rd_ptr;
   logic             do_push;
   logic             do_pop;

   assign empty   = (wr_ptr == rd_ptr);
   assign full    = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                    (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr[PTR_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr[PTR_W-1:0]] <= push_data;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (full && $stable(rd_ptr))); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !flush) |=> empty); // R6
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R7
endmodule

// File: rtl/msb_addr_decode.sv
module msb_addr_decode
   import msb_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);
   generate
      if (ADDR_W <= WIN_LSB) begin : g_bad_addr
         $error("msb_addr_decode: ADDR_W must exceed the register window");
      end
   endgenerate

   always_comb begin
      sel.hit = (addr[ADDR_W-1:WIN_LSB] == '0) && (addr[1:0] == 2'b00);
      sel.idx = reg_idx_e'(addr[WIN_LSB-1:2]);
   end
endmodule

// File: rtl/msb_axil_wr.sv
module msb_axil_wr
   import msb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       awvalid,
   output logic       awready,
   input  logic       wvalid,
   output logic       wready,
   output logic [1:0] bresp,
   output logic       bvalid,
   input  logic       bready,
   output logic       wr_fire
);
   logic bvalid_q;

   assign wr_fire = awvalid && wvalid && !bvalid_q;
   assign awready = wr_fire;
   assign wready  = wr_fire;
   assign bvalid  = bvalid_q;
   assign bresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n)       bvalid_q <= 1'b0;
      else if (wr_fire) bvalid_q <= 1'b1;
      else if (bready)  bvalid_q <= 1'b0;
   end

   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> bvalid); // R11
   AST_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bvalid) |-> $past(awvalid && wvalid)); // R11
endmodule

// File: rtl/msb_axil_rd.sv
module msb_axil_rd
   import msb_pkg::*;
#(
   parameter int unsigned NUM_CORES = 16,
   parameter logic [31:0] ID_WORD   = 32'hF202_0310
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arvalid,
   output logic              arready,
   input  reg_sel_t          sel,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic              tx_full,
   input  logic              rx_empty,
   input  logic [BYTE_W-1:0] rx_head,
   input  logic              ctrl_bit,
   input  logic [DATA_W-1:0] scratch,
   output logic              rx_pop
);
   logic              rvalid_q;
   logic              rd_fire;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] word;

   assign arready = !rvalid_q;
   assign rd_fire = arvalid && !rvalid_q;
   assign rx_pop  = rd_fire && sel.hit && (sel.idx == IDX_POP) && !rx_empty;
   assign rvalid  = rvalid_q;
   assign rdata   = rdata_q;
   assign rresp   = RESP_OKAY;

   always_comb begin
      word = '0;
      if (sel.hit) begin
         case (sel.idx)
            IDX_PUSH_ST: word = {{(DATA_W-1){1'b0}}, !tx_full};
            IDX_POP:     word = rx_empty ? '0 : {{(DATA_W-BYTE_W){1'b0}}, rx_head};
            IDX_POP_ST:  word = {{(DATA_W-1){1'b0}}, !rx_empty};
            IDX_CTRL:    word = {{(DATA_W-1){1'b0}}, ctrl_bit};
            IDX_ID:      word = ID_WORD;
            IDX_SCRATCH: word = scratch;
            IDX_NCORE:   word = DATA_W'(NUM_CORES);
            default:     word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (rd_fire) begin
         rvalid_q <= 1'b1;
         rdata_q  <= word;
      end else if (rready) begin
         rvalid_q <= 1'b0;
      end
   end

   AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> rvalid); // R11
   AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> $stable(rdata)); // R11
endmodule

// File: rtl/mmio_stream_bridge.sv
module mmio_stream_bridge
   import msb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned TX_DEPTH  = 16,
   parameter int unsigned RX_DEPTH  = 16,
   parameter int unsigned NUM_CORES = 16,
   parameter logic [31:0] ID_WORD   = 32'hF202_0310
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [31:0]       s_wdata,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [7:0]        tx_byte_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   input  logic [7:0]        rx_byte_i,
   input  logic              rx_valid_i,
   output logic              rx_ready_o,
   output logic              soft_reset_o
);
   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("mmio_stream_bridge: NUM_CORES must be at least 1");
      end
   endgenerate

   reg_sel_t          wsel;
   reg_sel_t          rsel;
   logic              wr_fire;
   logic              tx_push;
   logic              pulse_q;
   logic [DATA_W-1:0] scratch_q;
   logic              tx_empty, tx_full;
   logic              rx_empty, rx_full;
   logic [BYTE_W-1:0] rx_head;
   logic              rx_pop;

   msb_addr_decode #(.ADDR_W(ADDR_W)) u_wdec (.addr(s_awaddr), .sel(wsel));
   msb_addr_decode #(.ADDR_W(ADDR_W)) u_rdec (.addr(s_araddr), .sel(rsel));

   msb_axil_wr u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .awvalid (s_awvalid),
      .awready (s_awready),
      .wvalid  (s_wvalid),
      .wready  (s_wready),
      .bresp   (s_bresp),
      .bvalid  (s_bvalid),
      .bready  (s_bready),
      .wr_fire (wr_fire)
   );

   assign tx_push = wr_fire && wsel.hit && (wsel.idx == IDX_PUSH);

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= wr_fire && wsel.hit && (wsel.idx == IDX_CTRL) && s_wdata[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) scratch_q <= '0;
      else if (wr_fire && wsel.hit && (wsel.idx == IDX_SCRATCH)) scratch_q <= s_wdata;
   end

   msb_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (pulse_q),
      .push      (tx_push),
      .push_data (s_wdata[BYTE_W-1:0]),
      .pop       (tx_ready_i),
      .head      (tx_byte_o),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   msb_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (pulse_q),
      .push      (rx_valid_i),
      .push_data (rx_byte_i),
      .pop       (rx_pop),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   msb_axil_rd #(.NUM_CORES(NUM_CORES), .ID_WORD(ID_WORD)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .arvalid  (s_arvalid),
      .arready  (s_arready),
      .sel      (rsel),
      .rdata    (s_rdata),
      .rresp    (s_rresp),
      .rvalid   (s_rvalid),
      .rready   (s_rready),
      .tx_full  (tx_full),
      .rx_empty (rx_empty),
      .rx_head  (rx_head),
      .ctrl_bit (pulse_q),
      .scratch  (scratch_q),
      .rx_pop   (rx_pop)
   );

   assign tx_valid_o   = !tx_empty;
   assign rx_ready_o   = !rx_full;
   assign soft_reset_o = pulse_q;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset_o |=> !soft_reset_o); // R7
   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_reset_o) |-> $past(s_awvalid && s_wvalid && s_wdata[0])); // R7
   AST_SCRATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_reset_o && !(s_awvalid && s_wvalid)) |=> $stable(scratch_q)); // R9
endmodule

// File: tb/mmio_stream_bridge_tb.sv
module mmio_stream_bridge_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 12;
   localparam int QD         = 4;
   localparam int CORES      = 16;
   localparam logic [31:0] ID_EXP = 32'hF202_0310;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
   logic              awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
   logic [31:0]       wdata = '0;
   logic              awready, wready, bvalid, arready, rvalid;
   logic [1:0]        bresp, rresp;
   logic [31:0]       rdata;
   logic [7:0]        tx_byte, rx_byte = '0;
   logic              tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, soft_rst;

   int tests = 0;
   int fails = 0;
   int pulses = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmio_stream_bridge #(.ADDR_W(ADDR_W), .TX_DEPTH(QD), .RX_DEPTH(QD),
                        .NUM_CORES(CORES)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .tx_byte_o(tx_byte), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
      .rx_byte_i(rx_byte), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
      .soft_reset_o(soft_rst)
   );

   always @(negedge clk) if (rst_n && soft_rst) pulses <= pulses + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic axi_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      awaddr = a; wdata = d; awvalid = 1; wvalid = 1; bready = 1;
      #1;
      while (!(awready && wready)) begin @(negedge clk); #1; end
      @(negedge clk);
      awvalid = 0; wvalid = 0;
      check("R11 write response", {29'b0, bvalid, bresp}, 32'h4);
      @(negedge clk);
   endtask

   task automatic axi_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      araddr = a; arvalid = 1; rready = 1;
      #1;
      while (!arready) begin @(negedge clk); #1; end
      @(negedge clk);
      arvalid = 0;
      d = rdata;
      check("R11 read response", {29'b0, rvalid, rresp}, 32'h4);
      @(negedge clk);
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge clk);
      rx_byte = b; rx_valid = 1;
      @(negedge clk);
      rx_valid = 0;
   endtask

   task automatic tx_take(input logic [7:0] exp, input string req);
      check(req, {23'b0, tx_valid, tx_byte}, {23'b0, 1'b1, exp});
      tx_ready = 1;
      @(negedge clk);
      tx_ready = 0;
   endtask

   function automatic logic [7:0] pat(input int r, input int i);
      return 8'(r * 71 + i * 37 + 5);
   endfunction

   initial begin
      repeat (CLK_PERIOD * 15000) @(posedge clk);
      fails++;
      $display("FAIL R11 watchdog expired: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int p0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // reset state, all mapped offsets
      check("R12 reset tx_valid", {31'b0, tx_valid}, 0);
      check("R12 reset rx_ready", {31'b0, rx_ready}, 1);
      for (int k = 0; k < 8; k++) begin
         logic [31:0] e;
         case (k)
            1: e = 1; 5: e = ID_EXP; 7: e = CORES; default: e = 0;
         endcase
         axi_rd(ADDR_W'(k * 4), v);
         check($sformatf("R8 R2 R5 reset read offset %0d", k * 4), v, e);
      end

      // transmit sweeps: fill to full, overflow, drain in order
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < QD; i++) begin
            axi_rd(12'h004, v); check("R2 push status not full", v, 1);
            axi_wr(12'h000, {8'(r + 1), 8'hC3, 8'(i), pat(r, i)}); // R1 upper junk
         end
         axi_rd(12'h004, v); check("R2 push status full", v, 0);
         axi_wr(12'h000, 32'h0000_00EE); // R3 dropped
         for (int i = 0; i < QD; i++) tx_take(pat(r, i), "R1 transmit byte order");
         check("R3 dropped byte absent", {31'b0, tx_valid}, 0);
         axi_rd(12'h004, v); check("R2 push status after drain", v, 1);
      end

      // receive sweeps: fill, overflow, drain, underflow
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < QD; i++) begin
            check("R12 rx_ready with room", {31'b0, rx_ready}, 1);
            rx_push(pat(r + 5, i));
         end
         check("R12 rx_ready full", {31'b0, rx_ready}, 0);
         rx_push(8'h99); // R12 dropped
         axi_rd(12'h00C, v); check("R5 pop status not empty", v, 1);
         for (int i = 0; i < QD; i++) begin
            axi_rd(12'h008, v); check("R4 pop data order", v, {24'b0, pat(r + 5, i)});
         end
         axi_rd(12'h00C, v); check("R5 pop status empty", v, 0);
         axi_rd(12'h008, v); check("R6 empty pop reads zero", v, 0);
         rx_push(8'(8'h40 + r));
         axi_rd(12'h008, v); check("R6 empty pop left pointers", v, {24'b0, 8'(8'h40 + r)});
         axi_rd(12'h00C, v); check("R5 pop status drained", v, 0);
      end

      // scratch walking ones
      for (int b = 0; b < 32; b++) begin
         axi_wr(12'h018, 32'h1 << b);
         axi_rd(12'h018, v); check("R9 scratch walking one", v, 32'h1 << b);
      end

      // soft reset
      axi_wr(12'h018, 32'h1357_2468);
      for (int i = 0; i < 3; i++) axi_wr(12'h000, {24'b0, pat(9, i)});
      rx_push(8'h11); rx_push(8'h22);
      p0 = pulses;
      axi_wr(12'h010, 32'h0000_0000);
      check("R7 zero write no pulse", pulses - p0, 0);
      check("R7 zero write keeps tx", {31'b0, tx_valid}, 1);
      axi_wr(12'h010, 32'hFFFF_FFFF);
      check("R7 single pulse", pulses - p0, 1);
      check("R7 tx flushed", {31'b0, tx_valid}, 0);
      axi_rd(12'h00C, v); check("R7 rx flushed", v, 0);
      axi_rd(12'h010, v); check("R7 control reads zero", v, 0);
      axi_rd(12'h018, v); check("R9 scratch survives soft reset", v, 32'h1357_2468);
      axi_wr(12'h000, 32'h0000_0077);
      tx_take(8'h77, "R1 transmit after soft reset");

      // unmapped and misaligned
      p0 = pulses;
      axi_wr(12'h020, 32'hFFFF_FFFF);
      axi_wr(12'h001, 32'h0000_0055);
      axi_wr(12'h41C, 32'h0BAD_0BAD);
      axi_wr(12'h012, 32'hFFFF_FFFF);
      check("R10 unmapped write no tx push", {31'b0, tx_valid}, 0);
      check("R10 unmapped write no pulse", pulses - p0, 0);
      axi_rd(12'h018, v); check("R10 scratch unchanged", v, 32'h1357_2468);
      foreach (v[k]) if (k < 5) begin
         logic [ADDR_W-1:0] ua;
         case (k)
            0: ua = 12'h020; 1: ua = 12'h03C; 2: ua = 12'h116; 3: ua = 12'h016; default: ua = 12'hFFC;
         endcase
         axi_rd(ua, v); check("R10 unmapped reads zero", v, 0);
      end

      // held write response
      @(negedge clk);
      awaddr = 12'h018; wdata = 32'hA5A5_5A5A; awvalid = 1; wvalid = 1; bready = 0;
      #1; while (!awready) begin @(negedge clk); #1; end
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
         #1;
         check("R11 bvalid held, no new accept", {30'b0, bvalid, awready}, 32'h2);
         @(negedge clk);
      end
      bready = 1;
      @(negedge clk);
      awvalid = 0; wvalid = 0;
      @(negedge clk); @(negedge clk);
      // held read response
      @(negedge clk);
      araddr = 12'h014; arvalid = 1; rready = 0;
      @(negedge clk);
      arvalid = 0;
      for (int c = 0; c < 3; c++) begin
         check("R11 rvalid held, data stable", {rvalid, rdata[30:0]}, {1'b1, ID_EXP[30:0]});
         @(negedge clk);
      end
      rready = 1;
      @(negedge clk);
      axi_rd(12'h018, v); check("R9 scratch write with held response", v, 32'hA5A5_5A5A);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule